// File: doc/BRIEF.md
# Programmable Clock Phase and Duty Generator

This block builds two derived clocks from a slow reference clock. The block runs on a fast sampling clock, and one period of the prescaled reference equals 32 fast cycles. A 32-slot counter, restarted on every rising edge of the prescaled reference, stands in for a tapped delay line. Each output can be set to one of two waveforms. The first is a duty-adjusted copy that is high for the first n slots of each period. The second is a delayed copy: a square wave that rises n slots after the reference edge. The step count n runs from 1 to 31, so each step is 3.125 % of the period.

The I/O clock output has one more choice. It can carry the delayed copy divided by an integer from 1 to 8. The system clock output is never divided. Before any slot processing, an input prescaler divides the reference by 1 to 8. Software loads four 8-bit registers through a simple write port. The writes land in shadow copies, and the shadow copies go live together on the next prescaled-reference rising edge. A period therefore never mixes an old setting with a new one.

Top module: `clkPhaseDutyGen`

## Requirements
- R1: While reset is low, both outputs are low and every register clears. With the cleared settings, both outputs stay low even while the reference toggles.
- R2: The step register sets n. If bits [7:3] are 01111 or above, n = bits[7:3] + 1, and the value 11111 saturates to 31. Otherwise n = {bit 6, bits [2:0]} + 1, and bits [5:3] are ignored.
- R3: Select code 01 gives the duty copy, which is high in slots 0 to n-1. The duty copy appears only while bit 4 of the mode register is 1. With bit 4 at 0, code 01 drives the output low.
- R4: Select code 10 gives the delayed copy, which is high when (slot - n) mod 32 is below 16.
- R5: I/O select code 11 gives the delayed copy divided by d+1, where d is bits [6:4] of the divisor register. The divided output is high while perIdx*32 + (slot - n) mod 32 is below (d+1)*16. perIdx counts delayed-copy wraps from the first prescaled edge onward, modulo d+1.
- R6: Select code 00 on either output drives that output low. Code 11 on the system output (bits [7:6] of the output-select register) also drives it low.
- R7: Bit 0 of the mode register set to 1 forces both outputs low.
- R8: Bits [2:0] of the divisor register give p. The prescaled edge fires on the first reference rise after reset and then on every (p+1)-th rise. Each prescaled edge sets the slot to 0.
- R9: Register writes (address 0 mode, 1 output select, 2 step, 3 divisor) change the outputs only from the next prescaled edge onward.
- R10: The slot advances by one per fast cycle, modulo 32, after the first prescaled edge. The outputs are registered, so the sample taken after edge k reflects the slot value reached at edge k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, 32x the prescaled reference |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Reference clock, sampled on clk |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| ioClk | output | 1 | I/O clock: duty, delayed or divided-delayed |
| sysClk | output | 1 | System clock: duty or delayed, never divided |

## Verification
The bench builds the block with its default parameters: 5 slot bits (32 slots) and 3-bit divisor fields. At that size a sweep over every step count from 1 to 31 costs only a few thousand cycles. The sweep alternates between both step encodings, and every I/O divisor from 1 to 8 is also run at two phases. The reference period follows the prescaler setting (32, 16, 8 or 4 fast cycles). This keeps the prescaled period at 32 cycles, so the bench can predict every output sample from the cycle count alone.

// File: rtl/ccgPkg.sv
package ccgPkg;
  localparam int SLOT_BITS  = 5;
  localparam int SLOTS      = 1 << SLOT_BITS;
  localparam int DIV_BITS   = 3;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 2;
  localparam int IO_DIV_LSB = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE = 2'd0,
    ADDR_OSEL = 2'd1,
    ADDR_STEP = 2'd2,
    ADDR_DIV  = 2'd3
  } regAddr_e;

  // settings consumed by the datapath
  typedef struct packed {
    logic                bypass;
    logic                dutyEn;
    logic [1:0]          ioSel;
    logic [1:0]          sysSel;
    logic [REG_W-1:0]    step;
    logic [DIV_BITS-1:0] ioDiv;
  } dpCfg_t;

  typedef struct packed {
    dpCfg_t              dp;
    logic [DIV_BITS-1:0] preDiv;
  } cfg_t;

  typedef struct packed {
    logic                 run;
    logic [SLOT_BITS-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/ccgControl.sv
module ccgControl
  import ccgPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output strobe_t           strb,
  output logic              periodStart,
  output dpCfg_t            dpCfg
);
  logic                 refPrev;
  logic                 refRise;
  logic                 divRise;
  logic [DIV_BITS-1:0]  preCnt;
  logic [DIV_BITS-1:0]  preLimit;
  logic [SLOT_BITS-1:0] slot;
  logic                 run;
  cfg_t                 shadowCfg;
  cfg_t                 activeCfg;

  always_comb begin
    refRise  = refClk & ~refPrev;
    divRise  = refRise && (preCnt == '0);
    // the limit for the new period is the one that goes live at this edge
    preLimit = divRise ? shadowCfg.preDiv : activeCfg.preDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= '0;
    end else if (wrEn) begin
      case (regAddr_e'(wrAddr))
        ADDR_MODE: begin
          shadowCfg.dp.bypass <= wrData[0];
          shadowCfg.dp.dutyEn <= wrData[4];
        end
        ADDR_OSEL: begin
          shadowCfg.dp.ioSel  <= wrData[5:4];
          shadowCfg.dp.sysSel <= wrData[7:6];
        end
        ADDR_STEP: shadowCfg.dp.step <= wrData;
        default: begin
          shadowCfg.preDiv   <= wrData[DIV_BITS-1:0];
          shadowCfg.dp.ioDiv <= wrData[IO_DIV_LSB+DIV_BITS-1:IO_DIV_LSB];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev   <= 1'b0;
      preCnt    <= '0;
      slot      <= '0;
      run       <= 1'b0;
      activeCfg <= '0;
    end else begin
      refPrev <= refClk;
      if (refRise) begin
        preCnt <= (preCnt >= preLimit) ? '0 : preCnt + 1'b1;
      end
      if (divRise) begin
        slot      <= '0;
        run       <= 1'b1;
        activeCfg <= shadowCfg;
      end else if (run) begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign strb        = '{run: run, slot: slot};
  assign periodStart = divRise;
  assign dpCfg       = activeCfg.dp;
endmodule

// File: rtl/ccgOutMux.sv
module ccgOutMux (
  input  logic [1:0] sel,
  input  logic       bypass,
  input  logic       dutyEn,
  input  logic       dutyHi,
  input  logic       delayHi,
  input  logic       divHi,
  output logic       outNext
);
  always_comb begin
    outNext = 1'b0;
    if (!bypass) begin
      case (sel)
        2'b01:   outNext = dutyEn & dutyHi;
        2'b10:   outNext = delayHi;
        2'b11:   outNext = divHi;
        default: outNext = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ccgDatapath.sv
module ccgDatapath
  import ccgPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  dpCfg_t  dpCfg,
  output logic    ioClk,
  output logic    sysClk
);
  localparam int POS_W = DIV_BITS + SLOT_BITS;
  localparam logic [SLOT_BITS-1:0] HI_CODE   = 5'b01111;
  localparam logic [SLOT_BITS-1:0] SAT_CODE  = 5'b11111;
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(SLOTS - 1);

  logic [SLOT_BITS-1:0] stepHi;
  logic [SLOT_BITS-1:0] nVal;
  logic [SLOT_BITS-1:0] dSlot;
  logic [DIV_BITS-1:0]  perIdx;
  logic [POS_W-1:0]     divPos;
  logic [POS_W-1:0]     divHalf;
  logic                 dutyHi;
  logic                 delayHi;
  logic                 divHi;
  logic [1:0]           outNext;
  logic [1:0]           selVec [2];
  logic [1:0]           divVec;

  always_comb begin
    stepHi = dpCfg.step[REG_W-1:REG_W-SLOT_BITS];
    if (stepHi >= HI_CODE) begin
      nVal = (stepHi == SAT_CODE) ? SAT_CODE : stepHi + 1'b1;
    end else begin
      nVal = {1'b0, dpCfg.step[6], dpCfg.step[2:0]} + 1'b1;
    end
    dSlot   = strb.slot - nVal;
    dutyHi  = strb.slot < nVal;
    delayHi = !dSlot[SLOT_BITS-1];
    divPos  = {perIdx, dSlot};
    divHalf = POS_W'({1'b0, dpCfg.ioDiv} + 1'b1) << (SLOT_BITS - 1);
    divHi   = divPos < divHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perIdx <= '0;
    end else if (strb.run && dSlot == LAST_SLOT) begin
      perIdx <= (perIdx >= dpCfg.ioDiv) ? '0 : perIdx + 1'b1;
    end
  end

  assign selVec[0] = dpCfg.ioSel;
  assign selVec[1] = dpCfg.sysSel;
  assign divVec    = {1'b0, divHi};

  // index 0 drives the I/O clock, index 1 the undividable system clock
  for (genvar g = 0; g < 2; g++) begin : gOut
    ccgOutMux u_mux (
      .sel     (selVec[g]),
      .bypass  (dpCfg.bypass),
      .dutyEn  (dpCfg.dutyEn),
      .dutyHi  (dutyHi),
      .delayHi (delayHi),
      .divHi   (divVec[g]),
      .outNext (outNext[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioClk  <= 1'b0;
      sysClk <= 1'b0;
    end else begin
      ioClk  <= outNext[0];
      sysClk <= outNext[1];
    end
  end
endmodule

// File: rtl/clkPhaseDutyGen.sv
module clkPhaseDutyGen
  import ccgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refClk,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       ioClk,
  output logic       sysClk
);
  strobe_t strb;
  dpCfg_t  dpCfg;
  logic    periodStart;

  ccgControl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .refClk      (refClk),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .strb        (strb),
    .periodStart (periodStart),
    .dpCfg       (dpCfg)
  );

  ccgDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dpCfg  (dpCfg),
    .ioClk  (ioClk),
    .sysClk (sysClk)
  );
endmodule

// File: rtl/ccgChecker.sv
module ccgChecker
  import ccgPkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    periodStart,
  input strobe_t strb,
  input dpCfg_t  dpCfg,
  input logic    ioClk,
  input logic    sysClk
);
  assert_slot_resync_R8: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> (strb.slot == '0 && strb.run));

  assert_slot_advance_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !periodStart) |=> (strb.slot == $past(strb.slot) + 1'b1));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |=> $stable(dpCfg));

  assert_bypass_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    dpCfg.bypass |=> (!ioClk && !sysClk));

  assert_sys_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCfg.sysSel == 2'b00 || dpCfg.sysSel == 2'b11) |=> !sysClk);

  assert_io_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCfg.ioSel == 2'b00) |=> !ioClk);
endmodule

bind clkPhaseDutyGen ccgChecker u_ccgChecker (
  .clk         (clk),
  .rstN        (rstN),
  .periodStart (periodStart),
  .strb        (strb),
  .dpCfg       (dpCfg),
  .ioClk       (ioClk),
  .sysClk      (sysClk)
);

// File: tb/clkPhaseDutyGen_bench.sv
module clkPhaseDutyGen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refClk = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       ioClk;
  logic       sysClk;
  int         nChecks = 0;
  int         nFails = 0;

  always #10 clk = ~clk;

  clkPhaseDutyGen u_clkPhaseDutyGen (
    .clk    (clk),
    .rstN   (rstN),
    .refClk (refClk),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .ioClk  (ioClk),
    .sysClk (sysClk)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // encode a step count n (1..31); alternate don't-care filler per R2
  function automatic logic [7:0] encStep(input int n);
    logic [4:0] m;
    m = 5'(n - 1);
    if (n <= 15) return {1'b0, m[3], 3'b101, m[2:0]};
    return {m, 3'b010};
  endfunction

  function automatic logic expOut(input bit isIo, input logic [1:0] sel, input logic [7:0] modeV,
                                  input int n, input int d, input int m);
    int s, ds, cnt, per;
    s   = m % 32;
    ds  = (s - n + 32) % 32;
    cnt = (m >= n) ? ((m - n) / 32 + 1) : 0;
    per = cnt % (d + 1);
    if (modeV[0]) return 1'b0;
    case (sel)
      2'b01:   return modeV[4] && (s < n);
      2'b10:   return ds < 16;
      2'b11:   return isIo ? ((per * 32 + ds) < ((d + 1) * 16)) : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic runCase(input string tag, input logic [7:0] modeV, input logic [1:0] ioS,
                         input logic [1:0] sysS, input logic [7:0] stepV, input int n,
                         input int p, input int d, input int cycles, input bit mid,
                         input logic [7:0] newStep, input int newN);
    int per;
    int curN;
    per = 32 / (p + 1);
    rstN = 1'b0; refClk = 1'b0; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "ioClk in reset", ioClk, 1'b0);
    check("R1", "sysClk in reset", sysClk, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    regWrite(2'd0, modeV);
    regWrite(2'd1, {sysS, ioS, 4'b0000});
    regWrite(2'd2, stepV);
    regWrite(2'd3, {1'b0, 3'(d), 1'b0, 3'(p)});
    for (int k = 0; k < cycles; k++) begin
      refClk = ((k % per) < (per / 2));
      @(negedge clk);
      if (k >= 1) begin
        curN = (mid && (k - 1) >= 64) ? newN : n;
        check(tag, "ioClk", ioClk, expOut(1'b1, ioS, modeV, curN, d, k - 1));
        check(tag, "sysClk", sysClk, expOut(1'b0, sysS, modeV, curN, d, k - 1));
      end
      if (mid && k == 40) begin
        wrEn = 1'b1; wrAddr = 2'd2; wrData = newStep;
      end else begin
        wrEn = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: cleared settings keep both outputs low while the reference runs
    runCase("R1", 8'h00, 2'b00, 2'b00, 8'h00, 1, 0, 0, 80, 1'b0, 8'h00, 1);
    // R2 R3 R4 R10: every step count, duty on system, delay on I/O
    for (int n = 1; n <= 31; n++)
      runCase("R2_R3_R4_R10", 8'h10, 2'b10, 2'b01, encStep(n), n, 0, 0, 72, 1'b0, 8'h00, 1);
    // R2: alternate low-range form for 16, and saturation of 11111
    runCase("R2", 8'h10, 2'b10, 2'b01, 8'b0100_0111, 16, 0, 0, 72, 1'b0, 8'h00, 1);
    runCase("R2", 8'h10, 2'b10, 2'b01, 8'hFF, 31, 0, 0, 72, 1'b0, 8'h00, 1);
    // R3 R4: swapped roles
    runCase("R3_R4", 8'h10, 2'b01, 2'b10, encStep(7), 7, 0, 0, 72, 1'b0, 8'h00, 1);
    runCase("R3_R4", 8'h10, 2'b01, 2'b10, encStep(24), 24, 0, 0, 72, 1'b0, 8'h00, 1);
    // R3: duty code with duty submode off is low on both outputs
    runCase("R3", 8'h00, 2'b01, 2'b01, encStep(12), 12, 0, 0, 72, 1'b0, 8'h00, 1);
    // R5: every I/O divisor at two phases
    for (int d = 0; d < 8; d++) begin
      runCase("R5", 8'h10, 2'b11, 2'b10, encStep(3), 3, 0, d, 64 * (d + 1) + 40, 1'b0, 8'h00, 1);
      runCase("R5", 8'h10, 2'b11, 2'b10, encStep(20), 20, 0, d, 64 * (d + 1) + 40, 1'b0, 8'h00, 1);
    end
    // R6: system code 11 and I/O code 00 stay low
    runCase("R6", 8'h10, 2'b00, 2'b11, encStep(9), 9, 0, 5, 72, 1'b0, 8'h00, 1);
    // R7: bypass bit forces both outputs low
    runCase("R7", 8'h11, 2'b10, 2'b01, encStep(9), 9, 0, 0, 72, 1'b0, 8'h00, 1);
    // R8: prescalers with matching reference periods
    runCase("R8", 8'h10, 2'b10, 2'b01, encStep(9), 9, 1, 0, 100, 1'b0, 8'h00, 1);
    runCase("R8", 8'h10, 2'b10, 2'b01, encStep(17), 17, 3, 0, 100, 1'b0, 8'h00, 1);
    runCase("R8", 8'h10, 2'b11, 2'b01, encStep(29), 29, 7, 1, 140, 1'b0, 8'h00, 1);
    // R9: step rewritten mid-period applies from the next prescaled edge
    runCase("R9", 8'h10, 2'b00, 2'b10, encStep(5), 5, 0, 0, 130, 1'b1, encStep(21), 21);
    runCase("R9", 8'h10, 2'b01, 2'b10, encStep(30), 30, 1, 0, 130, 1'b1, encStep(2), 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule